// File: doc/BRIEF.md
# Pulse Width Bound Checker

This block watches one single-bit condition and measures how long each of its high phases lasts, in clock cycles. It flags a high phase that ends too early and one that runs too long. Both bounds are set by parameters. The input is sampled on the rising clock edge. An active-low reset clears the measurement and stops all checking.

A high phase that is still running is flagged as too long as soon as it goes past the upper bound. The flag is raised only once for that phase. A high phase that ends before reaching the lower bound is flagged in the cycle after the first low sample. A combined one-cycle fire pulse marks either violation. A sticky error bit records that at least one violation has been seen since the last reset.

The cycle counter stops at one past the upper bound, so a very long pulse can never wrap it. The block is meant to sit next to a design signal inside a larger chip and feed error collection logic.

Top module: `pulse_width_checker`

## Requirements
- R1: While `rst_ni` is low, every output is 0, the sticky bit included, and the width measurement is cleared.
- R2: A high phase that is sampled high on k consecutive edges, with 1 <= k < MIN_W, and then sampled low raises `short_o` for exactly one cycle. The flag is visible after the edge that takes the first low sample.
- R3: A high phase of MIN_W or more sampled cycles never raises `short_o` when it ends. This holds whether it ends below, at or above MAX_W.
- R4: On the edge that takes the (MAX_W+1)-th consecutive high sample, `long_o` rises for one cycle, while the condition is still high.
- R5: `long_o` is raised at most once per high phase, however long that phase lasts.
- R6: `fire_o` is high in exactly the cycles in which `short_o` or `long_o` is high. `short_o` and `long_o` are never high together.
- R7: `sticky_o` rises in the same cycle as the first `fire_o` pulse. It then stays high until reset.
- R8: A condition that is already high when reset is released is counted from the first rising edge after release. That edge counts as cycle 1.
- R9: A single low sample ends a high phase. The next high phase is measured from 1, independently of the previous one.
- R10: The internal width count saturates at MAX_W+1. A pulse hundreds of cycles long ends with no short flag and no second long flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cond_i | input | 1 | Condition whose high-phase width is bounded |
| fire_o | output | 1 | One-cycle pulse on any width violation |
| short_o | output | 1 | One-cycle pulse: high phase ended below MIN_W |
| long_o | output | 1 | One-cycle pulse: high phase passed MAX_W |
| sticky_o | output | 1 | Set by any violation, cleared only by reset |

## Verification
The condition is driven with pulses of every width from 1 to just above MAX_W. Widths below MIN_W, exactly MIN_W and exactly MAX_W separate a correct comparison from an off-by-one. A width of MAX_W+1 must flag and a width of MAX_W must not, which pins the long threshold. Very long pulses tell saturation apart from wrap-around, and show whether the flag fires once or repeatedly. Pulses separated by a single low cycle, and pulses that straddle reset release, show whether the count restarts correctly. Random runs of high and low lengths, with occasional resets, are compared against a cycle model in the bench.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

   // Bits needed to hold 0 .. max_w+1 (saturation value).
   function automatic int unsigned cnt_width(input int unsigned max_w);
      int unsigned w;
      w = $clog2(max_w + 2);
      if (w < 1) w = 1;
      return w;
   endfunction

   // Violation events produced by the bound evaluator for one edge.
   typedef struct packed {
      logic too_short;
      logic too_long;
   } pwc_event_t;

endpackage

// File: rtl/pwc_run_counter.sv
module pwc_run_counter #(
   parameter int unsigned MAX_W = 10,
   parameter int unsigned CW    = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          sample_i,
   output logic [CW-1:0] count_o
);
   localparam logic [CW-1:0] SAT = CW'(MAX_W + 1);

   logic [CW-1:0] count_q;

   // Counts consecutive high samples; a low sample restarts, the top value holds.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q <= '0;
      end else if (!sample_i) begin
         count_q <= '0;
      end else if (count_q != SAT) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count_o = count_q;

endmodule

// File: rtl/pwc_bound_eval.sv
module pwc_bound_eval
   import pwc_pkg::*;
#(
   parameter int unsigned MIN_W = 4,
   parameter int unsigned MAX_W = 10,
   parameter int unsigned CW    = 4
) (
   input  logic          sample_i,
   input  logic [CW-1:0] count_i,
   output pwc_event_t    ev_o
);
   localparam logic [CW-1:0] AT_MAX = CW'(MAX_W);

   // Too long: this high sample is the first one beyond the upper bound.
   assign ev_o.too_long = sample_i && (count_i == AT_MAX);

   // Too short: only meaningful when the lower bound exceeds one cycle.
   generate
      if (MIN_W > 1) begin : g_short
         localparam logic [CW-1:0] LOW_B = CW'(MIN_W);
         assign ev_o.too_short = !sample_i && (count_i != '0) && (count_i < LOW_B);
      end else begin : g_no_short
         logic unused_low;
         assign unused_low     = sample_i;
         assign ev_o.too_short = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pwc_flag_reg.sv
module pwc_flag_reg
   import pwc_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  pwc_event_t ev_i,
   output logic       short_o,
   output logic       long_o,
   output logic       fire_o,
   output logic       sticky_o
);
   logic short_q, long_q, fire_q, sticky_q;
   logic any_hit;

   assign any_hit = ev_i.too_short | ev_i.too_long;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         short_q  <= 1'b0;
         long_q   <= 1'b0;
         fire_q   <= 1'b0;
         sticky_q <= 1'b0;
      end else begin
         short_q  <= ev_i.too_short;
         long_q   <= ev_i.too_long;
         fire_q   <= any_hit;
         sticky_q <= sticky_q | any_hit;
      end
   end

   assign short_o  = short_q;
   assign long_o   = long_q;
   assign fire_o   = fire_q;
   assign sticky_o = sticky_q;

endmodule

// File: rtl/pulse_width_checker.sv
module pulse_width_checker
   import pwc_pkg::*;
#(
   parameter int unsigned MIN_W = 4,
   parameter int unsigned MAX_W = 10
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cond_i,
   output logic fire_o,
   output logic short_o,
   output logic long_o,
   output logic sticky_o
);
   localparam int unsigned CW = cnt_width(MAX_W);

   generate
      if (MIN_W < 1) begin : g_bad_min
         $error("pulse_width_checker: MIN_W must be at least 1");
      end
      if (MAX_W < MIN_W) begin : g_bad_max
         $error("pulse_width_checker: MAX_W must not be below MIN_W");
      end
   endgenerate

   logic [CW-1:0] run_cnt;
   pwc_event_t    ev;

   pwc_run_counter #(.MAX_W(MAX_W), .CW(CW)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sample_i(cond_i),
      .count_o (run_cnt)
   );

   pwc_bound_eval #(.MIN_W(MIN_W), .MAX_W(MAX_W), .CW(CW)) u_eval (
      .sample_i(cond_i),
      .count_i (run_cnt),
      .ev_o    (ev)
   );

   pwc_flag_reg u_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ev_i    (ev),
      .short_o (short_o),
      .long_o  (long_o),
      .fire_o  (fire_o),
      .sticky_o(sticky_o)
   );

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
   parameter int unsigned MIN_W = 4,
   parameter int unsigned MAX_W = 10,
   parameter int unsigned CW    = 4
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          cond_i,
   input logic          fire_o,
   input logic          short_o,
   input logic          long_o,
   input logic          sticky_o,
   input logic [CW-1:0] count_i
);
   localparam logic [CW-1:0] SAT = CW'(MAX_W + 1);

   // R1: outputs quiet whenever reset is sampled low.
   always @(posedge clk_i) begin
      if (!rst_ni) begin
         assert_reset_quiet_R1: assert (!fire_o && !short_o && !long_o && !sticky_o && count_i == '0);
      end
   end

   assert_short_after_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      short_o |-> !$past(cond_i));

   assert_long_at_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      long_o |-> (count_i == SAT));

   assert_long_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      long_o |=> !long_o);

   assert_flags_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({short_o, long_o}));

   assert_fire_matches_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o == (short_o || long_o));

   assert_sticky_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sticky_o |=> sticky_o);

   assert_sticky_with_fire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |-> sticky_o);

   assert_count_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(cond_i) |-> (count_i == '0));

   assert_count_sat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_i <= SAT);

endmodule

bind pulse_width_checker pwc_checker #(.MIN_W(MIN_W), .MAX_W(MAX_W), .CW(CW)) u_pwc_checker (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .cond_i  (cond_i),
   .fire_o  (fire_o),
   .short_o (short_o),
   .long_o  (long_o),
   .sticky_o(sticky_o),
   .count_i (run_cnt)
);

// File: tb/pulse_width_checker_bench.sv
`timescale 1ns/1ps
module pulse_width_checker_bench;
   localparam int MIN_W = 4;
   localparam int MAX_W = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cond = 1'b0;
   logic fire, shrt, lng, sticky;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   // reference model state
   int m_run = 0;
   bit m_short = 0, m_long = 0, m_fire = 0, m_sticky = 0;

   always #10 clk = ~clk;   // 50 MHz

   pulse_width_checker #(.MIN_W(MIN_W), .MAX_W(MAX_W)) u_pulse_width_checker (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .cond_i  (cond),
      .fire_o  (fire),
      .short_o (shrt),
      .long_o  (lng),
      .sticky_o(sticky)
   );

   function automatic void predict(input bit c, input bit r);
      if (!r) begin
         m_run = 0; m_short = 0; m_long = 0; m_fire = 0; m_sticky = 0;
      end else begin
         m_short = 0; m_long = 0;
         if (c) begin
            if (m_run == MAX_W) m_long = 1;
            if (m_run <= MAX_W) m_run++;
         end else begin
            if (m_run > 0 && m_run < MIN_W) m_short = 1;
            m_run = 0;
         end
         m_fire   = m_short | m_long;
         m_sticky = m_sticky | m_fire;
      end
   endfunction

   task automatic chk(input string req, input string name, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
      end
   endtask

   // Drive one sample, let the edge pass, compare at the following falling edge.
   task automatic step(input bit c, input bit r, input string tag);
      cond  = c;
      rst_n = r;
      predict(c, r);
      @(posedge clk);
      @(negedge clk);
      chk({tag, "/R2"}, "short_o",  shrt,   m_short);
      chk({tag, "/R4"}, "long_o",   lng,    m_long);
      chk({tag, "/R6"}, "fire_o",   fire,   m_fire);
      chk({tag, "/R7"}, "sticky_o", sticky, m_sticky);
   endtask

   task automatic pulse(input int hi, input int lo, input string tag);
      for (int i = 0; i < hi; i++) step(1'b1, 1'b1, tag);
      for (int i = 0; i < lo; i++) step(1'b0, 1'b1, tag);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      @(negedge clk);
      // R1: reset holds everything low even with the condition high
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R1");
      // R8: condition high across release; 3 counted samples, then low -> short
      pulse(3, 1, "R8");
      // R2: widths 1..MIN_W-1 flag short
      for (int w = 1; w < MIN_W; w++) pulse(w, 2, "R2");
      // R1: reset clears sticky
      step(1'b0, 1'b0, "R1");
      // R3: widths MIN_W and MAX_W do not flag
      pulse(MIN_W, 2, "R3");
      pulse(7, 1, "R3");
      pulse(MAX_W, 2, "R3");
      // R4: MAX_W+1 flags long, still no short at the end
      pulse(MAX_W + 1, 2, "R4");
      // R5: long pulse flags exactly once
      pulse(25, 2, "R5");
      // R9: single low cycle between pulses restarts the count
      pulse(MAX_W, 1, "R9");
      pulse(MAX_W, 1, "R9");
      pulse(2, 1, "R9");
      // R10: very long pulse, saturating count
      step(1'b0, 1'b0, "R10");
      pulse(300, 2, "R10");
      // random runs
      for (int s = 0; s < 1500; s++) begin
         int hi, lo;
         hi = $urandom_range(1, MAX_W + 4);
         lo = $urandom_range(1, 3);
         if ($urandom_range(0, 40) == 0) step($urandom_range(0, 1) == 1, 1'b0, "RND");
         pulse(hi, lo, "RND");
      end
      finish_run();
   end

endmodule